// File: doc/BRIEF.md
# Flash Controller Register Bank with Guarded Test Mode

This block is the software-visible register bank of a flash memory controller. It holds a read-only revision word, an interrupt status and mask pair, a transfer register, a data buffer register, a four-word data FIFO and a guarded test register. Accesses arrive on a simple single-cycle bus: the read data and the error flag are combinational answers to the strobe in the same cycle, and writes take effect at the next rising clock edge.

The test register unlocks three features, but only through a two-step protocol. A first write sets a key bit and nothing else. Later writes that keep the key bit at one may change the feature bits. Any write that clears the key bit locks the register again and turns off every feature. The map feature exposes the FIFO words in the address window 0x64 to 0x70. The access feature opens the transfer and buffer registers to writes and holds the external memory pins idle. The allow-interrupt feature lets software set interrupt pending bits.

Top module: `flashreg_bank`

## Requirements
- R1: After reset every register reads zero except the revision word, and `irq`, `pins_off` and `bus_err` are low.
- R2: The test register sits at 0x18. Bit 15 is the key, bit 2 is map, bit 1 is access and bit 0 is allow-interrupt. All other bits read as zero.
- R3: While the key is clear, a test-register write with bit 15 set sets only the key, and the register then reads 0x0000_8000. A write with bit 15 clear changes nothing.
- R4: While the key is set, a test-register write with bit 15 set loads bits 2..0 from the write data.
- R5: While the key is set, a test-register write with bit 15 clear clears the key and bits 2..0 together.
- R6: With map set, the words at 0x64, 0x68, 0x6C and 0x70 read and write FIFO entries 0 to 3, and each entry resets to zero. With map clear, any access in that window raises `bus_err`.
- R7: With access set, `pins_off` is high and the transfer register (0x10) and buffer register (0x14) accept writes. With access clear, writes to those two registers raise `bus_err` and leave them unchanged. Reads of both are always allowed.
- R8: The revision register at 0x00 always reads REV_VALUE (0x0001_0200 by default). A write to it raises `bus_err`.
- R9: A buffer write in access mode stores the word and sets pending bit 0, the buffer interrupt.
- R10: The status register at 0x08 holds one pending bit per interrupt source. With allow-interrupt clear, writing 1 to a bit clears it. With allow-interrupt set, writing 1 to a bit sets it. A pulse on `hw_evt` always sets the matching bit, and this set takes priority over a clear in the same cycle.
- R11: `irq` is high when any pending bit is set whose enable bit in the mask register (0x0C) is also set.
- R12: An access to an address that is not decoded (including a misaligned address) raises `bus_err` only in the cycle of the strobe and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle, zero otherwise |
| bus_err | output | 1 | Access error, valid in the strobe cycle |
| hw_evt | input | NIRQ | Hardware interrupt events, one per pending bit |
| irq | output | 1 | Interrupt request |
| pins_off | output | 1 | Holds the external memory pins inactive |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that the bus signals are stable across the whole strobe cycle, because the error and read-data checks look at the combinational answer in that cycle. The stimulus drives every access at a falling edge, raises exactly one strobe, and drops it just after the following rising edge. Hardware events are pulsed for a single cycle, either alone or together with a status write when the set-over-clear priority is under test.

// File: rtl/flashreg_pkg.sv
`timescale 1ns/1ps
package flashreg_pkg;

   // Register offsets (byte addresses, word aligned)
   localparam int unsigned OFS_REV  = 'h00;
   localparam int unsigned OFS_STAT = 'h08;
   localparam int unsigned OFS_MASK = 'h0C;
   localparam int unsigned OFS_XFER = 'h10;
   localparam int unsigned OFS_BUF  = 'h14;
   localparam int unsigned OFS_TEST = 'h18;

   // Test register bit positions
   localparam int unsigned KEY_BIT   = 15;
   localparam int unsigned MAP_BIT   = 2;
   localparam int unsigned ACC_BIT   = 1;
   localparam int unsigned ALLOW_BIT = 0;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_REV,
      SEL_STAT,
      SEL_MASK,
      SEL_XFER,
      SEL_BUF,
      SEL_TEST,
      SEL_FIFO
   } sel_e;

   typedef struct packed {
      logic key;
      logic map;
      logic acc;
      logic allow;
   } test_t;

endpackage

// File: rtl/test_unlock.sv
`timescale 1ns/1ps
module test_unlock
   import flashreg_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  test_t wr_val,
   output test_t state
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= '0;
      end else if (wr_en) begin
         if (!state.key) begin
            // Locked: only the key may move, everything else is dropped
            if (wr_val.key) state.key <= 1'b1;
         end else if (wr_val.key) begin
            state.map   <= wr_val.map;
            state.acc   <= wr_val.acc;
            state.allow <= wr_val.allow;
         end else begin
            state <= '0;
         end
      end
   end

endmodule

// File: rtl/irq_bank.sv
`timescale 1ns/1ps
module irq_bank #(
   parameter int NIRQ    = 8,
   parameter int BUF_IRQ = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NIRQ-1:0] hw_evt,
   input  logic            stat_wr,
   input  logic            mask_wr,
   input  logic [NIRQ-1:0] wdata,
   input  logic            allow,
   input  logic            buf_set,
   output logic [NIRQ-1:0] pending,
   output logic [NIRQ-1:0] mask,
   output logic            irq
);

   logic [NIRQ-1:0] sw_bits;
   logic [NIRQ-1:0] pend_nxt;

   always_comb begin
      sw_bits  = stat_wr ? wdata : '0;
      pend_nxt = allow ? (pending | sw_bits) : (pending & ~sw_bits);
      pend_nxt = pend_nxt | hw_evt;
      if (buf_set) pend_nxt[BUF_IRQ] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= '0;
         mask    <= '0;
      end else begin
         pending <= pend_nxt;
         if (mask_wr) mask <= wdata;
      end
   end

   assign irq = |(pending & mask);

endmodule

// File: rtl/fifo_window.sv
`timescale 1ns/1ps
module fifo_window #(
   parameter int DEPTH     = 4,
   parameter int WIDTH     = 32,
   parameter bit RESET_ENT = 1'b1,
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] ent [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic hit;
      assign hit = wr_en && (idx == IDX_W'(g));
      if (RESET_ENT) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n)   ent[g] <= '0;
            else if (hit) ent[g] <= wdata;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) ent[g] <= wdata;
         end
      end
   end

   assign rdata = ent[idx];

endmodule

// File: rtl/flashreg_bank.sv
`timescale 1ns/1ps
module flashreg_bank
   import flashreg_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          NIRQ       = 8,
   parameter int          BUF_IRQ    = 0,
   parameter int          FIFO_DEPTH = 4,
   parameter int          FIFO_BASE  = 'h64,
   parameter bit          FIFO_RESET = 1'b1,
   parameter logic [31:0] REV_VALUE  = 32'h0001_0200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_err,
   input  logic [NIRQ-1:0]   hw_evt,
   output logic              irq,
   output logic              pins_off
);

   localparam int IDX_W   = $clog2(FIFO_DEPTH);
   localparam int WIN_END = FIFO_BASE + 4 * (FIFO_DEPTH - 1);

   // Elaboration-time parameter checks
   if (NIRQ < 1 || NIRQ > 32) begin : g_bad_nirq
      $error("NIRQ must lie in 1..32");
   end
   if (BUF_IRQ < 0 || BUF_IRQ >= NIRQ) begin : g_bad_bufirq
      $error("BUF_IRQ must index a pending bit");
   end
   if (FIFO_DEPTH < 2 || (1 << IDX_W) != FIFO_DEPTH) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two, at least 2");
   end
   if (FIFO_BASE <= OFS_TEST || (FIFO_BASE % 4) != 0
       || WIN_END + 4 > (1 << ADDR_W)) begin : g_bad_base
      $error("FIFO window must be aligned, above the registers and inside the address space");
   end

   sel_e              sel;
   logic              win_hit;
   logic [ADDR_W-1:0] win_off;
   logic              acc_any;
   logic              we;
   test_t             tst;
   test_t             tst_wr;
   logic [31:0]       test_word;
   logic [31:0]       xfer_q;
   logic [31:0]       buf_q;
   logic [31:0]       fifo_rd;
   logic [NIRQ-1:0]   pending;
   logic [NIRQ-1:0]   mask;

   assign acc_any = bus_rd | bus_wr;
   assign win_off = bus_addr - ADDR_W'(FIFO_BASE);
   assign win_hit = (bus_addr >= ADDR_W'(FIFO_BASE)) && (bus_addr <= ADDR_W'(WIN_END))
                    && (bus_addr[1:0] == 2'b00);

   // Address decode
   always_comb begin
      sel = SEL_NONE;
      if (win_hit)                            sel = SEL_FIFO;
      else if (bus_addr == ADDR_W'(OFS_REV))  sel = SEL_REV;
      else if (bus_addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
      else if (bus_addr == ADDR_W'(OFS_MASK)) sel = SEL_MASK;
      else if (bus_addr == ADDR_W'(OFS_XFER)) sel = SEL_XFER;
      else if (bus_addr == ADDR_W'(OFS_BUF))  sel = SEL_BUF;
      else if (bus_addr == ADDR_W'(OFS_TEST)) sel = SEL_TEST;
   end

   // Error policy
   always_comb begin
      unique case (sel)
         SEL_NONE:         bus_err = acc_any;
         SEL_REV:          bus_err = bus_wr;
         SEL_XFER,
         SEL_BUF:          bus_err = bus_wr & ~tst.acc;
         SEL_FIFO:         bus_err = acc_any & ~tst.map;
         default:          bus_err = 1'b0;
      endcase
   end

   assign we = bus_wr & ~bus_err;

   // Guarded test register
   assign tst_wr = '{key:   bus_wdata[KEY_BIT],
                     map:   bus_wdata[MAP_BIT],
                     acc:   bus_wdata[ACC_BIT],
                     allow: bus_wdata[ALLOW_BIT]};

   test_unlock u_test (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (we && sel == SEL_TEST),
      .wr_val (tst_wr),
      .state  (tst)
   );

   always_comb begin
      test_word            = '0;
      test_word[KEY_BIT]   = tst.key;
      test_word[MAP_BIT]   = tst.map;
      test_word[ACC_BIT]   = tst.acc;
      test_word[ALLOW_BIT] = tst.allow;
   end

   // Interrupt status and mask
   irq_bank #(.NIRQ(NIRQ), .BUF_IRQ(BUF_IRQ)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_evt  (hw_evt),
      .stat_wr (we && sel == SEL_STAT),
      .mask_wr (we && sel == SEL_MASK),
      .wdata   (bus_wdata[NIRQ-1:0]),
      .allow   (tst.allow),
      .buf_set (we && sel == SEL_BUF),
      .pending (pending),
      .mask    (mask),
      .irq     (irq)
   );

   // Transfer and buffer registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_q <= '0;
         buf_q  <= '0;
      end else begin
         if (we && sel == SEL_XFER) xfer_q <= bus_wdata;
         if (we && sel == SEL_BUF)  buf_q  <= bus_wdata;
      end
   end

   // FIFO words visible through the test window
   fifo_window #(.DEPTH(FIFO_DEPTH), .WIDTH(32), .RESET_ENT(FIFO_RESET)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (we && sel == SEL_FIFO),
      .idx   (win_off[IDX_W+1:2]),
      .wdata (bus_wdata),
      .rdata (fifo_rd)
   );

   // Read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_rd && !bus_err) begin
         unique case (sel)
            SEL_REV:  bus_rdata = REV_VALUE;
            SEL_STAT: bus_rdata = 32'(pending);
            SEL_MASK: bus_rdata = 32'(mask);
            SEL_XFER: bus_rdata = xfer_q;
            SEL_BUF:  bus_rdata = buf_q;
            SEL_TEST: bus_rdata = test_word;
            SEL_FIFO: bus_rdata = fifo_rd;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign pins_off = tst.acc;

endmodule

// File: rtl/flashreg_chk.sv
`timescale 1ns/1ps
module flashreg_chk
   import flashreg_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int NIRQ       = 8,
   parameter int FIFO_DEPTH = 4,
   parameter int FIFO_BASE  = 'h64
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic              key_w,
   input logic [2:0]        tbits_w,
   input logic [31:0]       bus_rdata,
   input logic              bus_err,
   input logic [NIRQ-1:0]   hw_evt,
   input logic              irq,
   input logic              pins_off,
   input logic [31:0]       test_word
);

   localparam int WIN_END = FIFO_BASE + 4 * (FIFO_DEPTH - 1);

   logic at_test, at_rev, in_win;
   assign at_test = bus_addr == ADDR_W'(OFS_TEST);
   assign at_rev  = bus_addr == ADDR_W'(OFS_REV);
   assign in_win  = (bus_addr >= ADDR_W'(FIFO_BASE)) && (bus_addr <= ADDR_W'(WIN_END))
                    && (bus_addr[1:0] == 2'b00);

   p_test_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && at_test && !bus_err |-> bus_rdata == test_word);

   p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && at_test |-> bus_rdata[31:16] == '0 && bus_rdata[14:3] == '0);

   p_key_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && at_test && !test_word[15] && key_w |=> test_word == 32'h0000_8000);

   p_load_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && at_test && test_word[15] && key_w |=> test_word[2:0] == $past(tbits_w));

   p_drop_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && at_test && !key_w |=> test_word == 32'h0);

   p_window_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) && in_win && !test_word[2] |-> bus_err);

   p_pins_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pins_off) |-> $past(bus_wr && at_test));

   p_rev_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && at_rev |-> bus_err);

   p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_wr) && $past(hw_evt) == '0 |-> $stable(irq));

   p_err_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err && bus_wr |=> $stable(test_word));

   p_err_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_rd || bus_wr));

endmodule

bind flashreg_bank flashreg_chk #(
   .ADDR_W(ADDR_W), .NIRQ(NIRQ), .FIFO_DEPTH(FIFO_DEPTH), .FIFO_BASE(FIFO_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .key_w     (bus_wdata[15]),
   .tbits_w   (bus_wdata[2:0]),
   .bus_rdata (bus_rdata),
   .bus_err   (bus_err),
   .hw_evt    (hw_evt),
   .irq       (irq),
   .pins_off  (pins_off),
   .test_word (test_word)
);

// File: tb/test_flashreg_bank.sv
`timescale 1ns/1ps
module test_flashreg_bank;

   localparam int NV = 43;

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] wdata;
      logic [31:0] exp;
      logic        exp_err;
      logic [7:0]  req;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'h18, 32'h0,         32'h0,         1'b0, 8'd1 },  // R1 test reg zero
      '{1'b0, 8'h00, 32'h0,         32'h0001_0200, 1'b0, 8'd8 },  // R8 revision
      '{1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0,         1'b1, 8'd8 },  // R8 write errs
      '{1'b0, 8'h00, 32'h0,         32'h0001_0200, 1'b0, 8'd8 },  // R8 unchanged
      '{1'b0, 8'h64, 32'h0,         32'h0,         1'b1, 8'd6 },  // R6 window closed
      '{1'b1, 8'h18, 32'h0000_8007, 32'h0,         1'b0, 8'd3 },  // R3 first write
      '{1'b0, 8'h18, 32'h0,         32'h0000_8000, 1'b0, 8'd3 },  // R3 key only
      '{1'b1, 8'h18, 32'hFFFF_8006, 32'h0,         1'b0, 8'd4 },  // R4 map+access
      '{1'b0, 8'h18, 32'h0,         32'h0000_8006, 1'b0, 8'd2 },  // R2 reserved zero
      '{1'b1, 8'h64, 32'hA5A5_0001, 32'h0,         1'b0, 8'd6 },  // R6
      '{1'b1, 8'h70, 32'h1234_5678, 32'h0,         1'b0, 8'd6 },  // R6
      '{1'b0, 8'h64, 32'h0,         32'hA5A5_0001, 1'b0, 8'd6 },  // R6
      '{1'b0, 8'h70, 32'h0,         32'h1234_5678, 1'b0, 8'd6 },  // R6
      '{1'b0, 8'h68, 32'h0,         32'h0,         1'b0, 8'd6 },  // R6 reset entry
      '{1'b1, 8'h10, 32'hCAFE_F00D, 32'h0,         1'b0, 8'd7 },  // R7
      '{1'b0, 8'h10, 32'h0,         32'hCAFE_F00D, 1'b0, 8'd7 },  // R7
      '{1'b1, 8'h14, 32'h0BAD_BEEF, 32'h0,         1'b0, 8'd9 },  // R9
      '{1'b0, 8'h08, 32'h0,         32'h0000_0001, 1'b0, 8'd9 },  // R9 buffer irq
      '{1'b0, 8'h14, 32'h0,         32'h0BAD_BEEF, 1'b0, 8'd9 },  // R9
      '{1'b1, 8'h08, 32'h0000_0001, 32'h0,         1'b0, 8'd10},  // R10 W1C
      '{1'b0, 8'h08, 32'h0,         32'h0,         1'b0, 8'd10},  // R10
      '{1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0,         1'b0, 8'd11},  // R11 mask
      '{1'b0, 8'h0C, 32'h0,         32'h0000_00FF, 1'b0, 8'd11},  // R11
      '{1'b1, 8'h18, 32'h0000_8001, 32'h0,         1'b0, 8'd4 },  // R4 allow only
      '{1'b0, 8'h18, 32'h0,         32'h0000_8001, 1'b0, 8'd4 },  // R4
      '{1'b1, 8'h08, 32'h0000_0050, 32'h0,         1'b0, 8'd10},  // R10 sw set
      '{1'b0, 8'h08, 32'h0,         32'h0000_0050, 1'b0, 8'd10},  // R10
      '{1'b1, 8'h08, 32'h0000_0050, 32'h0,         1'b0, 8'd10},  // R10 no clear
      '{1'b0, 8'h08, 32'h0,         32'h0000_0050, 1'b0, 8'd10},  // R10
      '{1'b1, 8'h18, 32'h0000_0007, 32'h0,         1'b0, 8'd5 },  // R5 drop
      '{1'b0, 8'h18, 32'h0,         32'h0,         1'b0, 8'd5 },  // R5
      '{1'b1, 8'h18, 32'h0000_0007, 32'h0,         1'b0, 8'd3 },  // R3 no key
      '{1'b0, 8'h18, 32'h0,         32'h0,         1'b0, 8'd3 },  // R3
      '{1'b0, 8'h64, 32'h0,         32'h0,         1'b1, 8'd6 },  // R6 closed again
      '{1'b1, 8'h10, 32'h0000_0001, 32'h0,         1'b1, 8'd7 },  // R7 locked write
      '{1'b0, 8'h10, 32'h0,         32'hCAFE_F00D, 1'b0, 8'd7 },  // R7 unchanged
      '{1'b1, 8'h14, 32'h0000_0002, 32'h0,         1'b1, 8'd7 },  // R7 locked write
      '{1'b0, 8'h14, 32'h0,         32'h0BAD_BEEF, 1'b0, 8'd7 },  // R7 unchanged
      '{1'b0, 8'h3C, 32'h0,         32'h0,         1'b1, 8'd12},  // R12 undecoded
      '{1'b1, 8'h40, 32'h0000_0005, 32'h0,         1'b1, 8'd12},  // R12
      '{1'b0, 8'h1A, 32'h0,         32'h0,         1'b1, 8'd12},  // R12 misaligned
      '{1'b1, 8'h08, 32'h0000_0050, 32'h0,         1'b0, 8'd10},  // R10 clear
      '{1'b0, 8'h08, 32'h0,         32'h0,         1'b0, 8'd10}   // R10
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic [7:0]  hw_evt = '0;
   logic        irq;
   logic        pins_off;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   flashreg_bank i_flashreg_bank (
      .clk, .rst_n, .bus_addr, .bus_rd, .bus_wr, .bus_wdata,
      .bus_rdata, .bus_err, .hw_evt, .irq, .pins_off
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_op(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                         output logic [31:0] rd, output logic er);
      @(negedge clk);
      bus_addr  = addr;
      bus_wdata = wd;
      bus_wr    = wr;
      bus_rd    = ~wr;
      #2;
      rd = bus_rdata;
      er = bus_err;
      @(posedge clk);
      #1;
      bus_wr = 1'b0;
      bus_rd = 1'b0;
   endtask

   initial begin
      logic [31:0] rd;
      logic        er;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk({31'b0, irq},      32'h0, "R1 irq after reset");
      chk({31'b0, pins_off}, 32'h0, "R1 pins_off after reset");
      chk({31'b0, bus_err},  32'h0, "R1 err idle");

      for (int i = 0; i < NV; i++) begin
         bus_op(VECS[i].wr, VECS[i].addr, VECS[i].wdata, rd, er);
         chk({31'b0, er}, {31'b0, VECS[i].exp_err},
             $sformatf("R%0d err vec %0d", VECS[i].req, i));
         if (!VECS[i].wr)
            chk(rd, VECS[i].exp, $sformatf("R%0d rdata vec %0d", VECS[i].req, i));
      end

      // R11: hardware event with mask enabled raises irq
      @(negedge clk);
      hw_evt = 8'h04;
      @(posedge clk);
      #1 hw_evt = '0;
      @(negedge clk);
      chk({31'b0, irq}, 32'h1, "R11 irq on masked event");
      bus_op(1'b0, 8'h08, 32'h0, rd, er);
      chk(rd, 32'h4, "R10 hw event sets pending");
      // R11: mask off drops irq
      bus_op(1'b1, 8'h0C, 32'h0, rd, er);
      @(negedge clk);
      chk({31'b0, irq}, 32'h0, "R11 irq masked");
      // R10: hardware set wins over software clear in the same cycle
      @(negedge clk);
      hw_evt = 8'h04;
      bus_op(1'b1, 8'h08, 32'h4, rd, er);
      hw_evt = '0;
      bus_op(1'b0, 8'h08, 32'h0, rd, er);
      chk(rd, 32'h4, "R10 set beats clear");
      bus_op(1'b1, 8'h08, 32'h4, rd, er);
      bus_op(1'b0, 8'h08, 32'h0, rd, er);
      chk(rd, 32'h0, "R10 clear alone");
      // R7: access mode drives pins_off
      bus_op(1'b1, 8'h18, 32'h0000_8000, rd, er);
      bus_op(1'b1, 8'h18, 32'h0000_8002, rd, er);
      @(negedge clk);
      chk({31'b0, pins_off}, 32'h1, "R7 pins_off in access mode");
      bus_op(1'b1, 8'h18, 32'h0000_0000, rd, er);
      @(negedge clk);
      chk({31'b0, pins_off}, 32'h0, "R7 pins_off after lock");
      // R12: error lasts only for the strobe cycle
      bus_op(1'b0, 8'h3C, 32'h0, rd, er);
      chk({31'b0, er}, 32'h1, "R12 err on strobe");
      @(negedge clk);
      chk({31'b0, bus_err}, 32'h0, "R12 err after strobe");

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule